// File: doc/BRIEF.md
# Device-side MMU control and fault register block

This block is the software-facing register file of a device-side address translation unit. A host reads and writes 32-bit registers through a simple valid/write/address/data port. The registers set the translation mode (off, running, stalled), the page-table base and configuration, and issue TLB invalidation commands. They also report faults. The translation datapath lives outside this block. It receives the active table base and configuration, the translation enable and stall levels, and single-cycle flush commands. It sends back one pulse per fault class together with the offending address.

A fault pulse sets its interrupt status bit and raises the interrupt output. It stores the address in the capture register belonging to its class and forces the unit into the stalled state. Software reads the status, takes the lowest pending fault, clears it with a write-one-to-clear mask and writes the run code to resume. Table-base and configuration writes made while translation is on are held back until a flush-all command, so the TLB never mixes old entries with a new table. When the major version equals 3, two prefetch window start/end pairs are present.

Top module: `iommu_ctl_regs`

## Requirements
- R1: After synchronous reset the mode is off, xlate_en, xlate_stall, irq, flush_all, flush_entry and bus_rvalid are 0, and tbl_base, tbl_cfg, flush_page, bus_rdata and both prefetch outputs are 0.
- R2: A write to offset 0x000 of exactly 0x0 selects off (xlate_en=0, xlate_stall=0), 0x5 selects running (xlate_en=1, xlate_stall=0) and 0x7 selects stalled (xlate_en=1, xlate_stall=1). Any other value leaves the mode unchanged. Reading 0x000 returns the current code.
- R3: While the mode is running or stalled, a pulse on fault_pulse[i] sets bit i of the interrupt status (offset 0x018). The bit order is: 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write protection. irq is the OR of the status bits. While off, pulses are ignored.
- R4: An accepted fault puts the unit in the stalled state on the same edge, overriding a control write in that cycle. It stays stalled until a later write of 0x5 (or 0x0).
- R5: An accepted fault stores fault_addr in its class register. Page fault goes to 0x024. Write multi-hit, write security and write protection go to 0x028. Read multi-hit, read security and read access go to 0x02C. Bus error goes to 0x030.
- R6: Writing a mask to 0x01C clears each status bit whose mask bit is 1. A fault of the same class in the same cycle keeps its bit set.
- R7: The summary register at 0x008 returns bit 0 = running, bit 1 = stalled, bit 4 = any fault pending, bits 10:8 = index of the lowest set status bit (0 when none), and all other bits 0.
- R8: Writes to 0x014 (table base) and 0x004 (config) read back at once. tbl_base and tbl_cfg follow them at once only while the mode is off. Otherwise they keep the old values until a flush-all command copies the new ones.
- R9: A write to 0x00C with bit 0 set gives a one-cycle flush_all pulse after the write edge. With bit 0 clear it does nothing. 0x00C reads 0.
- R10: A write to 0x010 with bit 0 set gives a one-cycle flush_entry pulse and loads flush_page with wdata[31:12]. With bit 0 clear it does nothing. 0x010 reads 0.
- R11: 0x034 reads {VER_MAJOR, VER_MINOR} with the major version in bits 31:28. When the major version is 3, offsets 0x04C/0x050 (window 0 start/end) and 0x054/0x058 (window 1 start/end) are read/write. They drive pfb_start/pfb_end, with window 0 in the low 32 bits. Otherwise these offsets read 0 and the outputs stay 0.
- R12: A read returns its data with bus_rvalid=1 in the cycle after the request. Without a read, bus_rvalid=0 and bus_rdata=0. Unmapped offsets and 0x01C read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| fault_pulse | input | NUM_FAULT | One pulse per fault class from the translation path |
| fault_addr | input | 32 | Address that caused the fault |
| irq | output | 1 | Any fault pending |
| xlate_en | output | 1 | Translation switched on |
| xlate_stall | output | 1 | Translation stalled |
| tbl_base | output | 32 | Page-table base in use |
| tbl_cfg | output | 32 | Configuration in use |
| flush_all | output | 1 | Invalidate every TLB entry |
| flush_entry | output | 1 | Invalidate one page |
| flush_page | output | 20 | Page number for flush_entry |
| pfb_start | output | 64 | Prefetch window start addresses |
| pfb_end | output | 64 | Prefetch window end addresses |

## Verification
Every register update, fault capture, mode change and flush pulse is visible one edge after the request or pulse that causes it. Read data arrives one edge after the read request. The bench drives inputs at the falling edge and steps a behavioural model by exactly one edge for each stimulus. At the next falling edge it compares every output against that model, so a result that comes one cycle early or late is flagged. Read data is checked against the model value computed when the request was issued.

// File: rtl/iommu_regs_pkg.sv
// Shared constants for the MMU control register block.
// Assumes a 32-bit register width and byte offsets of at most 8 bits.
package iommu_regs_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned NUM_SLOT  = 4;

    // Mode codes as written to the control register
    typedef enum logic [2:0] {
        MODE_OFF   = 3'd0,
        MODE_RUN   = 3'd5,
        MODE_STALL = 3'd7
    } mode_e;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_CFG    = 8'h04;
    localparam logic [7:0] OFS_SUMM   = 8'h08;
    localparam logic [7:0] OFS_FLALL  = 8'h0C;
    localparam logic [7:0] OFS_FLENT  = 8'h10;
    localparam logic [7:0] OFS_BASE   = 8'h14;
    localparam logic [7:0] OFS_ISTAT  = 8'h18;
    localparam logic [7:0] OFS_ICLR   = 8'h1C;
    localparam logic [7:0] OFS_SLOT0  = 8'h24;
    localparam logic [7:0] OFS_VER    = 8'h34;
    localparam logic [7:0] OFS_PFB0   = 8'h4C;

    // Capture slot for a fault class: 0 page, 1 write side, 2 read side, 3 bus error
    function automatic logic [1:0] capt_slot(input int unsigned idx);
        case (idx)
            0:       capt_slot = 2'd0;
            1, 4, 5: capt_slot = 2'd2;
            2, 6, 7: capt_slot = 2'd1;
            3:       capt_slot = 2'd3;
            default: capt_slot = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/iommu_ctl_mode.sv
// Translation mode register.
// Holds off / running / stalled. An accepted fault forces the stalled state
// with priority over a software write. Codes other than the three known
// ones are ignored. Assumes fault_hit is already gated by the mode.
module iommu_ctl_mode
    import iommu_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_code,
    input  logic              fault_hit,
    output mode_e             mode_q
);

    // Mode update: reset, fault override, then software code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
        end else if (fault_hit) begin
            mode_q <= MODE_STALL;
        end else if (wr_en) begin
            case (wr_code)
                32'h0:   mode_q <= MODE_OFF;
                32'h5:   mode_q <= MODE_RUN;
                32'h7:   mode_q <= MODE_STALL;
                default: mode_q <= mode_q;
            endcase
        end
    end

    // R4
    fault_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit |=> (mode_q == MODE_STALL));

    // R2
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fault_hit && wr_code != 32'h0 && wr_code != 32'h5 && wr_code != 32'h7)
        |=> $stable(mode_q));

endmodule

// File: rtl/iommu_fault_log.sv
// Fault status, per-class address capture and lowest-pending encoder.
// Assumes fault_set arrives already gated by the mode. A set and a clear
// of the same bit in one cycle leave the bit set.
module iommu_fault_log
    import iommu_regs_pkg::*;
#(
    parameter int unsigned NUM_FAULT = 8,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned IDX_W    = $clog2(NUM_FAULT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAULT-1:0]  fault_set,
    input  logic [DATA_W-1:0]     fault_addr,
    input  logic                  clr_en,
    input  logic [NUM_FAULT-1:0]  clr_mask,
    output logic [NUM_FAULT-1:0]  status_q,
    output logic [DATA_W-1:0]     slot_q [NUM_SLOT],
    output logic [IDX_W-1:0]      low_idx,
    output logic                  pending
);

    logic [NUM_SLOT-1:0]  slot_hit;
    logic [NUM_FAULT-1:0] clr_eff;

    // Which capture slots receive the address this cycle
    always_comb begin
        slot_hit = '0;
        for (int i = 0; i < NUM_FAULT; i++) begin
            if (fault_set[i]) slot_hit[capt_slot(i)] = 1'b1;
        end
    end

    assign clr_eff = clr_en ? clr_mask : '0;

    // Status bits: clear first, then new faults on top
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_eff) | fault_set;
    end

    // One capture register per slot
    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)           slot_q[s] <= '0;
            else if (slot_hit[s]) slot_q[s] <= fault_addr;
        end
    end

    // Lowest set status bit wins the report
    always_comb begin
        low_idx = '0;
        for (int i = NUM_FAULT - 1; i >= 0; i--) begin
            if (status_q[i]) low_idx = IDX_W'(i);
        end
    end

    assign pending = |status_q;

    // R3
    fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_set != '0) |=> ((status_q & $past(fault_set)) == $past(fault_set)));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((status_q & $past(clr_mask & ~fault_set)) == '0));

    // R5
    page_capt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_set[0] |=> (slot_q[0] == $past(fault_addr)));

endmodule

// File: rtl/iommu_flush_shadow.sv
// Staged and active copies of table base and configuration, plus the TLB
// flush command pulses. Staged values read back at once. Active values
// follow directly only while translation is off, otherwise on flush-all.
// Assumes at most one register write per cycle.
module iommu_flush_shadow #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    localparam int unsigned PAGE_W    = DATA_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlate_off,
    input  logic              base_wr,
    input  logic              cfg_wr,
    input  logic              flall_wr,
    input  logic              flent_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] base_stage,
    output logic [DATA_W-1:0] cfg_stage,
    output logic [DATA_W-1:0] base_act,
    output logic [DATA_W-1:0] cfg_act,
    output logic              flush_all,
    output logic              flush_entry,
    output logic [PAGE_W-1:0] flush_page
);

    logic flall_trig;
    logic flent_trig;

    assign flall_trig = flall_wr & wdata[0];
    assign flent_trig = flent_wr & wdata[0];

    // Staged registers take every write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_stage <= '0;
            cfg_stage  <= '0;
        end else begin
            if (base_wr) base_stage <= wdata;
            if (cfg_wr)  cfg_stage  <= wdata;
        end
    end

    // Active copies: direct while off, else loaded by flush-all
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_act <= '0;
            cfg_act  <= '0;
        end else if (flall_trig) begin
            base_act <= base_stage;
            cfg_act  <= cfg_stage;
        end else begin
            if (base_wr && xlate_off) base_act <= wdata;
            if (cfg_wr && xlate_off)  cfg_act  <= wdata;
        end
    end

    // Single-cycle flush commands and the page number
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_all   <= 1'b0;
            flush_entry <= 1'b0;
            flush_page  <= '0;
        end else begin
            flush_all   <= flall_trig;
            flush_entry <= flent_trig;
            if (flent_trig) flush_page <= wdata[DATA_W-1:PAGE_SHIFT];
        end
    end

    // R9
    flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |-> $past(flall_wr && wdata[0]));

    // R8
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && !xlate_off) |=> $stable(base_act));

    // R10
    entry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_entry |-> $past(flent_wr && wdata[0]));

endmodule

// File: rtl/iommu_ctl_regs.sv
// Register block of a device-side MMU: address decode, read mux, mode,
// fault log, staged table settings, flush commands and, for major version
// 3, two prefetch windows. Assumes a single-beat bus where a read returns
// one cycle after its request and writes take effect on the request edge.
module iommu_ctl_regs
    import iommu_regs_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned NUM_FAULT = 8,
    parameter logic [3:0]  VER_MAJOR = 4'd3,
    parameter logic [27:0] VER_MINOR = 28'h0000021,
    localparam int unsigned PAGE_W   = REG_W - 12,
    localparam int unsigned NUM_PFBR = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic                  bus_rvalid,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic [NUM_FAULT-1:0]  fault_pulse,
    input  logic [REG_W-1:0]      fault_addr,
    output logic                  irq,
    output logic                  xlate_en,
    output logic                  xlate_stall,
    output logic [REG_W-1:0]      tbl_base,
    output logic [REG_W-1:0]      tbl_cfg,
    output logic                  flush_all,
    output logic                  flush_entry,
    output logic [PAGE_W-1:0]     flush_page,
    output logic [2*REG_W-1:0]    pfb_start,
    output logic [2*REG_W-1:0]    pfb_end
);

    localparam int unsigned IDX_W   = $clog2(NUM_FAULT);
    localparam bit          HAS_PFB = (VER_MAJOR == 4'd3);

    logic                 wr, rd;
    logic                 hit_ctrl, hit_cfg, hit_base, hit_flall, hit_flent, hit_iclr;
    mode_e                mode_q;
    logic [NUM_FAULT-1:0] fault_set;
    logic [NUM_FAULT-1:0] status_q;
    logic [REG_W-1:0]     slot_q [NUM_SLOT];
    logic [IDX_W-1:0]     low_idx;
    logic                 pending;
    logic [REG_W-1:0]     base_stage, cfg_stage;
    logic [REG_W-1:0]     summ_word;
    logic [REG_W-1:0]     rd_word;
    logic [REG_W-1:0]     pfb_q [NUM_PFBR];
    logic [REG_W-1:0]     pfb_rd_word;
    logic                 pfb_rd_hit;

    assign wr = bus_valid & bus_write;
    assign rd = bus_valid & ~bus_write;

    assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_cfg   = (bus_addr == ADDR_W'(OFS_CFG));
    assign hit_base  = (bus_addr == ADDR_W'(OFS_BASE));
    assign hit_flall = (bus_addr == ADDR_W'(OFS_FLALL));
    assign hit_flent = (bus_addr == ADDR_W'(OFS_FLENT));
    assign hit_iclr  = (bus_addr == ADDR_W'(OFS_ICLR));

    // Faults count only while translation is switched on
    assign fault_set = (mode_q != MODE_OFF) ? fault_pulse : '0;

    iommu_ctl_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr & hit_ctrl),
        .wr_code   (bus_wdata),
        .fault_hit (|fault_set),
        .mode_q    (mode_q)
    );

    iommu_fault_log #(
        .NUM_FAULT (NUM_FAULT),
        .DATA_W    (REG_W)
    ) u_flog (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_set  (fault_set),
        .fault_addr (fault_addr),
        .clr_en     (wr & hit_iclr),
        .clr_mask   (bus_wdata[NUM_FAULT-1:0]),
        .status_q   (status_q),
        .slot_q     (slot_q),
        .low_idx    (low_idx),
        .pending    (pending)
    );

    iommu_flush_shadow #(
        .DATA_W     (REG_W),
        .PAGE_SHIFT (12)
    ) u_flush (
        .clk         (clk),
        .rst_n       (rst_n),
        .xlate_off   (mode_q == MODE_OFF),
        .base_wr     (wr & hit_base),
        .cfg_wr      (wr & hit_cfg),
        .flall_wr    (wr & hit_flall),
        .flent_wr    (wr & hit_flent),
        .wdata       (bus_wdata),
        .base_stage  (base_stage),
        .cfg_stage   (cfg_stage),
        .base_act    (tbl_base),
        .cfg_act     (tbl_cfg),
        .flush_all   (flush_all),
        .flush_entry (flush_entry),
        .flush_page  (flush_page)
    );

    // Prefetch windows exist only for major version 3
    if (HAS_PFB) begin : g_pfb
        // Window registers, contiguous from OFS_PFB0
        always_ff @(posedge clk) begin
            for (int k = 0; k < NUM_PFBR; k++) begin
                if (!rst_n) pfb_q[k] <= '0;
                else if (wr && bus_addr == ADDR_W'(int'(OFS_PFB0) + 4 * k)) pfb_q[k] <= bus_wdata;
            end
        end
        // Read selection among the window registers
        always_comb begin
            pfb_rd_word = '0;
            pfb_rd_hit  = 1'b0;
            for (int k = 0; k < NUM_PFBR; k++) begin
                if (bus_addr == ADDR_W'(int'(OFS_PFB0) + 4 * k)) begin
                    pfb_rd_word = pfb_q[k];
                    pfb_rd_hit  = 1'b1;
                end
            end
        end
    end else begin : g_no_pfb
        always_comb begin
            for (int k = 0; k < NUM_PFBR; k++) pfb_q[k] = '0;
            pfb_rd_word = '0;
            pfb_rd_hit  = 1'b0;
        end
    end

    assign pfb_start = {pfb_q[2], pfb_q[0]};
    assign pfb_end   = {pfb_q[3], pfb_q[1]};

    // Summary word: run, stall, pending, lowest index
    always_comb begin
        summ_word             = '0;
        summ_word[0]          = (mode_q == MODE_RUN);
        summ_word[1]          = (mode_q == MODE_STALL);
        summ_word[4]          = pending;
        summ_word[8 +: IDX_W] = low_idx;
    end

    // Read data selection by offset
    always_comb begin
        rd_word = '0;
        if (hit_ctrl)                              rd_word = REG_W'(mode_q);
        else if (hit_cfg)                          rd_word = cfg_stage;
        else if (bus_addr == ADDR_W'(OFS_SUMM))    rd_word = summ_word;
        else if (hit_base)                         rd_word = base_stage;
        else if (bus_addr == ADDR_W'(OFS_ISTAT))   rd_word = REG_W'(status_q);
        else if (bus_addr == ADDR_W'(OFS_VER))     rd_word = {VER_MAJOR, VER_MINOR};
        else if (pfb_rd_hit)                       rd_word = pfb_rd_word;
        else begin
            for (int s = 0; s < NUM_SLOT; s++) begin
                if (bus_addr == ADDR_W'(int'(OFS_SLOT0) + 4 * s)) rd_word = slot_q[s];
            end
        end
    end

    // Registered read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd;
            bus_rdata  <= rd ? rd_word : '0;
        end
    end

    assign irq         = |status_q;
    assign xlate_en    = (mode_q != MODE_OFF);
    assign xlate_stall = (mode_q == MODE_STALL);

    // R12
    read_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> bus_rvalid);

    // R12
    idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (!bus_rvalid && bus_rdata == '0));

    // R3
    off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OFF) |=> ((status_q & ~$past(status_q)) == '0));

    // R2
    run_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_ctrl && bus_wdata == 32'h5 && fault_set == '0) |=> (xlate_en && !xlate_stall));

    // R4
    irq_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> xlate_stall);

endmodule

// File: tb/iommu_ctl_regs_tb.sv
// Bench: behavioural model stepped once per clock and compared every cycle.
module iommu_ctl_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [7:0]  fault_pulse = '0;
    logic [31:0] fault_addr = '0;
    logic        irq, xlate_en, xlate_stall, flush_all, flush_entry;
    logic [31:0] tbl_base, tbl_cfg;
    logic [19:0] flush_page;
    logic [63:0] pfb_start, pfb_end;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    iommu_ctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .fault_pulse(fault_pulse), .fault_addr(fault_addr),
        .irq(irq), .xlate_en(xlate_en), .xlate_stall(xlate_stall),
        .tbl_base(tbl_base), .tbl_cfg(tbl_cfg), .flush_all(flush_all),
        .flush_entry(flush_entry), .flush_page(flush_page),
        .pfb_start(pfb_start), .pfb_end(pfb_end)
    );

    // Model state
    int          m_mode = 0;
    logic [31:0] m_base_s = 0, m_base_a = 0, m_cfg_s = 0, m_cfg_a = 0;
    logic [31:0] m_capt [4] = '{default: 0};
    logic [31:0] m_pfb [4] = '{default: 0};
    logic [7:0]  m_st = 0;
    logic        m_fa = 0, m_fe = 0, m_rv = 0;
    logic [19:0] m_page = 0;
    logic [31:0] m_rdata = 0;
    string       m_rtag = "R12";

    function automatic int slot_of(int i);
        if (i == 0) return 0;
        if (i == 3) return 3;
        if (i == 1 || i == 4 || i == 5) return 2;
        return 1;
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        logic [31:0] w = 0;
        case (a)
            8'h00: w = m_mode;
            8'h04: w = m_cfg_s;
            8'h08: begin
                w[0] = (m_mode == 5);
                w[1] = (m_mode == 7);
                w[4] = (m_st != 0);
                for (int i = 7; i >= 0; i--) if (m_st[i]) w[10:8] = i[2:0];
            end
            8'h14: w = m_base_s;
            8'h18: w = {24'h0, m_st};
            8'h24, 8'h28, 8'h2C, 8'h30: w = m_capt[(a - 8'h24) / 4];
            8'h34: w = {4'h3, 28'h0000021};
            8'h4C, 8'h50, 8'h54, 8'h58: w = m_pfb[(a - 8'h4C) / 4];
            default: w = 0;
        endcase
        return w;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3", "irq", irq, m_st != 0);
        chk("R2", "xlate_en", xlate_en, m_mode != 0);
        chk("R4", "xlate_stall", xlate_stall, m_mode == 7);
        chk("R8", "tbl_base", tbl_base, m_base_a);
        chk("R8", "tbl_cfg", tbl_cfg, m_cfg_a);
        chk("R9", "flush_all", flush_all, m_fa);
        chk("R10", "flush_entry", flush_entry, m_fe);
        chk("R10", "flush_page", flush_page, m_page);
        chk("R12", "rvalid", bus_rvalid, m_rv);
        chk(m_rtag, "rdata", bus_rdata, m_rdata);
        chk("R11", "pfb_start", pfb_start, {m_pfb[2], m_pfb[0]});
        chk("R11", "pfb_end", pfb_end, {m_pfb[3], m_pfb[1]});
    endtask

    // One clock: compare, drive, advance model by one edge
    task automatic step(logic v, logic w, logic [7:0] a, logic [31:0] d,
                        logic [7:0] fp, logic [31:0] fa, string tag);
        logic [7:0] fset;
        @(negedge clk);
        compare_all();
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
        fault_pulse = fp; fault_addr = fa;
        m_rv = v && !w;
        m_rdata = m_rv ? model_read(a) : 32'h0;
        m_rtag = m_rv ? tag : "R12";
        fset = (m_mode != 0) ? fp : 8'h0;
        m_fa = v && w && a == 8'h0C && d[0];
        m_fe = v && w && a == 8'h10 && d[0];
        if (m_fe) m_page = d[31:12];
        if (m_fa) begin m_base_a = m_base_s; m_cfg_a = m_cfg_s; end
        if (v && w && a == 8'h14) begin m_base_s = d; if (m_mode == 0) m_base_a = d; end
        if (v && w && a == 8'h04) begin m_cfg_s = d; if (m_mode == 0) m_cfg_a = d; end
        if (v && w && a == 8'h1C) m_st = m_st & ~d[7:0];
        m_st = m_st | fset;
        for (int i = 0; i < 8; i++) if (fset[i]) m_capt[slot_of(i)] = fa;
        if (v && w && (a == 8'h4C || a == 8'h50 || a == 8'h54 || a == 8'h58))
            m_pfb[(a - 8'h4C) / 4] = d;
        if (fset != 0) m_mode = 7;
        else if (v && w && a == 8'h00 && (d == 0 || d == 5 || d == 7)) m_mode = d;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        step(1, 1, a, d, 0, 0, "R12");
    endtask
    task automatic rd(logic [7:0] a, string tag);
        step(1, 0, a, 0, 0, 0, tag);
    endtask
    task automatic flt(logic [7:0] m, logic [31:0] fa);
        step(0, 0, 0, 0, m, fa, "R12");
    endtask
    task automatic idle();
        step(0, 0, 0, 0, 0, 0, "R12");
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "xlate_en", xlate_en, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "tbl_base", tbl_base, 0);
        chk("R1", "rvalid", bus_rvalid, 0);
        chk("R1", "flush_all", flush_all, 0);
        chk("R1", "pfb_start", pfb_start, 0);
        rst_n = 1'b1;
        idle();
        rd(8'h00, "R1");
        rd(8'h34, "R11");
        rd(8'h08, "R7");
        rd(8'h20, "R12");
        rd(8'h1C, "R12");
        // R8: direct while off
        wr(8'h14, 32'h0000_1000);
        wr(8'h04, 32'h1);
        rd(8'h14, "R8");
        // R2: codes
        wr(8'h00, 32'h5);
        rd(8'h00, "R2");
        wr(8'h00, 32'h3);
        rd(8'h00, "R2");
        wr(8'h00, 32'h105);
        rd(8'h08, "R7");
        // R8/R9: staged while on
        wr(8'h14, 32'h0000_2000);
        wr(8'h04, 32'h3);
        idle();
        rd(8'h14, "R8");
        wr(8'h0C, 32'h0);
        idle();
        wr(8'h0C, 32'h1);
        wr(8'h0C, 32'h1);
        idle();
        rd(8'h0C, "R9");
        // R10
        wr(8'h10, 32'h1234_5001);
        idle();
        wr(8'h10, 32'hABCD_E000);
        idle();
        rd(8'h10, "R10");
        // R3..R7: each class alone
        for (int i = 0; i < 8; i++) begin
            flt(8'(1 << i), 32'hF000_0000 + 32'(i) * 32'h1111);
            rd(8'h18, "R3");
            rd(8'h08, "R7");
            rd(8'h00, "R4");
            wr(8'h00, 32'h5);
            rd(8'h00, "R4");
            rd(8'h24 + 8'(4 * slot_of(i)), "R5");
            wr(8'h1C, 32'(1 << i));
            rd(8'h18, "R6");
        end
        // several at once, lowest reported
        flt(8'h28, 32'hDEAD_0040);
        rd(8'h08, "R7");
        rd(8'h30, "R5");
        rd(8'h2C, "R5");
        // clear and set of the same bit in one cycle
        step(1, 1, 8'h1C, 32'h08, 8'h08, 32'h0BAD_0000, "R12");
        rd(8'h18, "R6");
        wr(8'h1C, 32'h20);
        rd(8'h18, "R6");
        rd(8'h08, "R7");
        // fault overrides a control write in the same cycle
        step(1, 1, 8'h00, 32'h5, 8'h80, 32'h7777_0000, "R12");
        rd(8'h00, "R4");
        wr(8'h1C, 32'hFF);
        wr(8'h00, 32'h0);
        // R3: ignored while off
        flt(8'hFF, 32'h1357_0000);
        idle();
        rd(8'h18, "R3");
        rd(8'h24, "R3");
        wr(8'h00, 32'h7);
        rd(8'h08, "R2");
        wr(8'h00, 32'h0);
        // R11: prefetch windows
        wr(8'h4C, 32'h1000_0000);
        wr(8'h50, 32'h1FFF_FFFF);
        wr(8'h54, 32'h2000_0000);
        wr(8'h58, 32'h2FFF_FFFF);
        rd(8'h50, "R11");
        rd(8'h54, "R11");
        rd(8'h5C, "R12");
        idle();
        idle();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule